// File: doc/BRIEF.md
# Token-Aware Store Queue Matcher

This block is an eight-entry store queue whose entries are searched by load addresses and drained in order to memory. Three kinds of entry share the queue: ordinary 64-bit stores, arm entries and disarm entries. Arm and disarm entries mark a 64-byte memory line as holding, or no longer holding, a security token. They carry a one-bit token tag in place of a line of data, so the queue never holds line-wide payloads.

A load lookup compares the load against every held entry in the same cycle. Ordinary stores are matched on 8-byte words. Token entries are matched on 64-byte lines by a separate comparator bank. The youngest matching entry decides the result:

- An exact word hit on a store forwards that store's data.
- A partial overlap with a store stalls the load.
- A hit on an arm entry raises a violation, and no data is forwarded.
- A hit on a disarm entry sends the load to memory.

The oldest entry is offered to memory through a valid/ready handshake. It is offered with its opcode, its address and its token bit.

Top module: `tok_lsq_matcher`

## Requirements
- R1: After reset the queue is empty: `mem_valid` is 0, `enq_ready` is 1, and every load outcome output is 0.
- R2: An entry is accepted on a clock edge where `enq_valid` and `enq_ready` are both 1. `enq_ready` is 0 while 8 entries are held, and an entry presented at that time is discarded.
- R3: The oldest entry is presented on the `mem_*` outputs and is removed on an edge where `mem_valid` and `mem_ready` are both 1. While `mem_ready` is 0, the presented entry holds steady. Entries leave in arrival order.
- R4: Opcode encoding is 0 for store, 1 for arm and 2 for disarm. An arm or disarm entry is presented with `mem_token` equal to 1 and `mem_data` equal to 0. A store is presented with `mem_token` equal to 0 and its data.
- R5: A load spans the 8 bytes starting at `ld_addr`. If `ld_addr` is 8-byte aligned and the youngest matching entry is a store to the same word (`addr[31:3]`), `ld_fwd_valid` is 1 and `ld_fwd_data` equals that store's data.
- R6: When several stores write the same word, the youngest of them supplies the forwarded data.
- R7: If the youngest matching entry is a store whose word is one of the load's words, but the load is not aligned to exactly that word, `ld_stall` is 1 and `ld_fwd_valid` is 0.
- R8: An arm entry matches when its line (`addr[31:6]`) equals the line of the load's first byte or of its last byte. If such an arm is the youngest match, `ld_violation` is 1 and neither forwarding nor stall is signalled.
- R9: If the youngest match is a disarm entry, all three load outcome outputs are 0, which means the load reads memory.
- R10: When both store and token entries match a load, the younger entry decides the outcome.
- R11: With no matching entry, or with `ld_valid` at 0, all load outcome outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enq_valid | input | 1 | Enqueue request |
| enq_op | input | 2 | Entry kind: 0 store, 1 arm, 2 disarm |
| enq_addr | input | 32 | Byte address of the entry |
| enq_data | input | 64 | Store data; ignored for arm and disarm |
| enq_ready | output | 1 | Queue has room |
| ld_valid | input | 1 | Load lookup request |
| ld_addr | input | 32 | Load byte address (8-byte access) |
| ld_fwd_valid | output | 1 | Data forwarded from a store |
| ld_fwd_data | output | 64 | Forwarded data |
| ld_violation | output | 1 | Load touches an armed token line |
| ld_stall | output | 1 | Partial overlap with a store |
| mem_valid | output | 1 | Oldest entry offered to memory |
| mem_ready | input | 1 | Memory accepts the offered entry |
| mem_op | output | 2 | Opcode of the offered entry |
| mem_addr | output | 32 | Address of the offered entry |
| mem_data | output | 64 | Data of the offered entry (0 for token entries) |
| mem_token | output | 1 | Token bit of the offered entry |

## Verification
The load outcome is combinational over the held entries. The bench therefore applies each load address after a falling edge and samples the outcome 1 time unit later, in the same cycle and before any enqueue or retirement can change the contents. Enqueues and retirements take effect at the next rising edge. The bench drives them at a falling edge and examines the `mem_*` outputs and `enq_ready` at the following falling edge, after exactly one register update. Every byte load address from 0 to 0x13F is swept against a reference queue that the bench keeps itself.

// File: rtl/tok_lsq_matcher.sv
module tok_lsq_matcher #(
  parameter int DEPTH  = 8,
  parameter int AW     = 32,
  parameter int DW     = 64,
  parameter int WORD_B = 3,
  parameter int LINE_B = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enq_valid,
  input  logic [1:0]    enq_op,
  input  logic [AW-1:0] enq_addr,
  input  logic [DW-1:0] enq_data,
  output logic          enq_ready,
  input  logic          ld_valid,
  input  logic [AW-1:0] ld_addr,
  output logic          ld_fwd_valid,
  output logic [DW-1:0] ld_fwd_data,
  output logic          ld_violation,
  output logic          ld_stall,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic [1:0]    mem_op,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data,
  output logic          mem_token
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [1:0] OP_ST = 2'd0, OP_ARM = 2'd1, OP_DIS = 2'd2;
  localparam logic [AW-1:0] SPAN = AW'((1 << WORD_B) - 1);

  logic [1:0]    e_op   [DEPTH];
  logic [AW-1:0] e_addr [DEPTH];
  logic [DW-1:0] e_data [DEPTH];
  logic [PW-1:0] head, tail;
  logic [CW-1:0] count;

  wire push = enq_valid && enq_ready;
  wire pop  = mem_valid && mem_ready;

  assign enq_ready = count != CW'(DEPTH);
  assign mem_valid = count != '0;
  assign mem_op    = e_op[head];
  assign mem_addr  = e_addr[head];
  assign mem_token = e_op[head] != OP_ST;
  assign mem_data  = mem_token ? '0 : e_data[head];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (push) begin
        e_op[tail]   <= enq_op;
        e_addr[tail] <= enq_addr;
        if (enq_op == OP_ST) e_data[tail] <= enq_data;
        tail <= tail + 1'b1;
      end
      if (pop) head <= head + 1'b1;
      count <= count + CW'(push) - CW'(pop);
    end
  end

  wire [AW-1:0] ld_last = ld_addr + SPAN;
  wire [AW-WORD_B-1:0] w0 = ld_addr[AW-1:WORD_B];
  wire [AW-WORD_B-1:0] w1 = ld_last[AW-1:WORD_B];
  wire [AW-LINE_B-1:0] l0 = ld_addr[AW-1:LINE_B];
  wire [AW-LINE_B-1:0] l1 = ld_last[AW-1:LINE_B];
  wire aligned = ld_addr[WORD_B-1:0] == '0;

  logic [DEPTH-1:0] st_hit, st_exact, tok_hit;
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    wire [AW-WORD_B-1:0] ew = e_addr[g][AW-1:WORD_B];
    wire [AW-LINE_B-1:0] el = e_addr[g][AW-1:LINE_B];
    assign st_hit[g]   = (e_op[g] == OP_ST) && (ew == w0 || ew == w1);
    assign st_exact[g] = (e_op[g] == OP_ST) && aligned && ew == w0;
    assign tok_hit[g]  = (e_op[g] != OP_ST) && (el == l0 || el == l1);
  end

  logic          win;
  logic [PW-1:0] win_idx;
  always_comb begin
    win     = 1'b0;
    win_idx = head;
    for (int i = 0; i < DEPTH; i++) begin
      if (CW'(i) < count) begin
        if (st_hit[head + PW'(i)] || tok_hit[head + PW'(i)]) begin
          win     = 1'b1;
          win_idx = head + PW'(i);
        end
      end
    end
  end

  wire hit = ld_valid && win;
  assign ld_fwd_valid = hit && st_exact[win_idx];
  assign ld_fwd_data  = ld_fwd_valid ? e_data[win_idx] : '0;
  assign ld_stall     = hit && st_hit[win_idx] && !st_exact[win_idx];
  assign ld_violation = hit && tok_hit[win_idx] && e_op[win_idx] == OP_ARM;

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  a_r2_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (!enq_ready && !pop) |=> count == $past(count));
  a_r3_pop_count: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> count == $past(count) - 1'b1);
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> mem_valid && $stable(mem_addr) && $stable(mem_op));
  a_r4_token_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_token) |-> mem_data == '0);
  a_r8_viol_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    ld_violation |-> !ld_fwd_valid && !ld_stall);
  a_r11_idle_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_valid || !mem_valid) |-> !ld_fwd_valid && !ld_violation && !ld_stall);
endmodule

// File: tb/test_tok_lsq_matcher.sv
module test_tok_lsq_matcher;
  localparam int PERIOD = 10;
  logic clk = 0, rst_n = 0;
  logic enq_valid = 0; logic [1:0] enq_op = 0;
  logic [31:0] enq_addr = 0; logic [63:0] enq_data = 0;
  logic enq_ready;
  logic ld_valid = 0; logic [31:0] ld_addr = 0;
  logic ld_fwd_valid, ld_violation, ld_stall; logic [63:0] ld_fwd_data;
  logic mem_valid, mem_ready = 0, mem_token;
  logic [1:0] mem_op; logic [31:0] mem_addr; logic [63:0] mem_data;

  tok_lsq_matcher i_tok_lsq_matcher (.*);
  always #(PERIOD/2) clk = ~clk;

  int vectors = 0, errors = 0;
  bit done = 0;
  int q_op [9]; logic [31:0] q_addr [9]; logic [63:0] q_data [9]; int qn = 0;

  task automatic report();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    report();
  end

  // kind: 0 miss, 1 forward, 2 stall, 3 violation, 4 disarm miss
  task automatic model(input logic [31:0] a, output int kind, output logic [63:0] d);
    logic [31:0] z = a + 32'd7;
    kind = 0; d = 0;
    for (int i = 0; i < qn; i++) begin
      if (q_op[i] == 0) begin
        if (q_addr[i][31:3] == a[31:3] || q_addr[i][31:3] == z[31:3]) begin
          if (a[2:0] == 0 && q_addr[i][31:3] == a[31:3]) begin kind = 1; d = q_data[i]; end
          else begin kind = 2; d = 0; end
        end
      end else if (q_addr[i][31:6] == a[31:6] || q_addr[i][31:6] == z[31:6]) begin
        kind = (q_op[i] == 1) ? 3 : 4; d = 0;
      end
    end
  endtask

  task automatic check_load(input logic [31:0] a);
    int k; logic [63:0] d; string tag;
    model(a, k, d);
    @(negedge clk); ld_valid = 1; ld_addr = a; #1;
    case (k)
      0: tag = "R11"; 1: tag = "R5 R6"; 2: tag = "R7"; 3: tag = "R8 R10"; default: tag = "R9";
    endcase
    vectors++;
    if (ld_fwd_valid !== (k == 1) || ld_stall !== (k == 2) || ld_violation !== (k == 3)
        || (k == 1 && ld_fwd_data !== d)) begin
      errors++;
      $display("FAIL %s addr=%h: actual fwd=%b stall=%b viol=%b data=%h expected fwd=%b stall=%b viol=%b data=%h",
               tag, a, ld_fwd_valid, ld_stall, ld_violation, ld_fwd_data, k == 1, k == 2, k == 3, d);
    end
    ld_valid = 0;
  endtask

  task automatic enq(input int op, input logic [31:0] a, input logic [63:0] d);
    @(negedge clk);
    enq_valid = 1; enq_op = 2'(op); enq_addr = a; enq_data = d;
    if (enq_ready && qn < 8) begin q_op[qn] = op; q_addr[qn] = a; q_data[qn] = d; qn++; end
    @(negedge clk); enq_valid = 0;
  endtask

  task automatic chk_head(input string tag);
    logic [63:0] ed = (q_op[0] == 0) ? q_data[0] : 64'd0;
    vectors++;
    if (mem_valid !== 1 || mem_op !== 2'(q_op[0]) || mem_addr !== q_addr[0]
        || mem_data !== ed || mem_token !== (q_op[0] != 0)) begin
      errors++;
      $display("FAIL %s: actual v=%b op=%0d a=%h d=%h t=%b expected v=1 op=%0d a=%h d=%h t=%b",
               tag, mem_valid, mem_op, mem_addr, mem_data, mem_token,
               q_op[0], q_addr[0], ed, q_op[0] != 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
    vectors++;  // R1
    if (mem_valid !== 0 || enq_ready !== 1 || ld_fwd_valid !== 0 || ld_violation !== 0 || ld_stall !== 0) begin
      errors++;
      $display("FAIL R1: actual mem_valid=%b enq_ready=%b expected 0 1", mem_valid, enq_ready);
    end
    check_load(32'h8);  // R11 empty
    enq(0, 32'h008, 64'h1111_0000_0000_0001);
    enq(0, 32'h048, 64'h2222_0000_0000_0002);
    enq(1, 32'h080, 64'hDEAD);
    enq(0, 32'h088, 64'h3333_0000_0000_0003);
    enq(0, 32'h00C, 64'h4444_0000_0000_0004);  // same word as first: R6
    enq(0, 32'h0D0, 64'h5555_0000_0000_0005);
    enq(2, 32'h0C5, 64'hBEEF);
    enq(1, 32'h13F, 64'hCAFE);
    @(negedge clk); #1;
    vectors++;  // R2 full
    if (enq_ready !== 0) begin errors++; $display("FAIL R2: actual enq_ready=%b expected 0", enq_ready); end
    enq(0, 32'h200, 64'h9999);  // discarded, R2
    for (int a = 0; a < 32'h140; a++) check_load(32'(a));
    @(negedge clk); ld_valid = 0; ld_addr = 32'h080; #1;
    vectors++;  // R11 idle load
    if (ld_violation !== 0 || ld_fwd_valid !== 0 || ld_stall !== 0) begin
      errors++; $display("FAIL R11: actual viol=%b fwd=%b expected 0 0", ld_violation, ld_fwd_valid);
    end
    chk_head("R3");
    @(negedge clk); chk_head("R3 hold");
    while (qn > 0) begin
      chk_head("R3 R4");
      mem_ready = 1;
      @(negedge clk); mem_ready = 0;
      for (int i = 0; i < 8; i++) begin
        q_op[i] = q_op[i+1]; q_addr[i] = q_addr[i+1]; q_data[i] = q_data[i+1];
      end
      qn--;
    end
    #1;
    vectors++;  // R2 discarded entry never retired, R3 drained
    if (mem_valid !== 0 || enq_ready !== 1) begin
      errors++; $display("FAIL R2 R3: actual mem_valid=%b enq_ready=%b expected 0 1", mem_valid, enq_ready);
    end
    report();
  end
endmodule